// File: doc/BRIEF.md
# SerDes Mode and Direction Controller

This block turns the static configuration pins of a combined 12-bit serializer/deserializer into the enables and controls of its data path. A two-bit mode code selects one of three reference-clock ranges or, when both bits are low, a power-down state that also acts as the device reset. A direction pin picks serializer or deserializer operation, and a multiplier pin picks between the plain and the overclocked PLL ratio for the serializer.

The controller also watches a reference clock for activity, lets the PLL run only while that reference is alive, and holds the internal logic in reset for a fixed number of reference edges after the PLL is enabled. A direction change is made break-before-make: both data-path drivers are off for at least one cycle before the new side is enabled. The inverted direction is passed straight through to `dir_out`, so a second device can be chained as a slave. All control inputs are asynchronous and are synchronized to the free-running `clk`.

Top module: `serdes_mode_ctrl`

## Requirements
- R1: When `{sel_b, sel_a}` is 00 the block is powered down: `pll_en`=0, `core_rst_n`=0, `ser_en`=`des_en`=0, `par_hiz`=`link_hiz`=1 and `range_code`=00.
- R2: While running, `dir_in`=1 enables the serializer only (`ser_en`=1, `des_en`=0) and `dir_in`=0 enables the deserializer only (`des_en`=1, `ser_en`=0).
- R3: `dir_out` is the inverse of `dir_in` with no register in the path.
- R4: `mult_frac` (1 = 7-1/3 ratio, 0 = 7 ratio) follows `mult_sel` only when the configuration is serializer; in deserializer configuration it is 0.
- R5: In serializer configuration `range_code` equals `{sel_b, sel_a}` (01 high range, 10 low range, 11 middle range); in deserializer configuration or power-down it is 00.
- R6: After leaving power-down `pll_en` stays 0 until a reference rising edge has been seen.
- R7: If no rising edge of `ref_clk` arrives for 256 `clk` cycles, `ref_lost` rises and `pll_en`, `core_rst_n`, `ser_en` and `des_en` drop; a new edge clears `ref_lost` and restarts bring-up.
- R8: After `pll_en` rises, `core_rst_n` stays 0 until the 16th following reference rising edge, then goes to 1.
- R9: `ser_en` and `des_en` are never 1 together and never swap in consecutive cycles; a direction change leaves at least one cycle with both at 0.
- R10: `link_hiz` is 0 exactly when `ser_en` is 1 and `par_hiz` is 0 exactly when `des_en` is 1; otherwise both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_a | input | 1 | Mode code bit 0 |
| sel_b | input | 1 | Mode code bit 1 |
| dir_in | input | 1 | 1 = serializer, 0 = deserializer |
| mult_sel | input | 1 | 1 = overclocked PLL ratio |
| ref_clk | input | 1 | Reference clock whose activity is watched |
| dir_out | output | 1 | Inverted `dir_in` for a slave device |
| ser_en | output | 1 | Serializer data path enable |
| des_en | output | 1 | Deserializer data path enable |
| mult_frac | output | 1 | Selected multiplier, 1 = 7-1/3 |
| range_code | output | 2 | Reference range code, 00 = none |
| pll_en | output | 1 | PLL enable |
| core_rst_n | output | 1 | Active-low reset for the core |
| ref_lost | output | 1 | Reference clock missing |
| par_hiz | output | 1 | Parallel data port in high impedance |
| link_hiz | output | 1 | Serial link outputs in high impedance |

## Verification
Bring-up is tried with the reference stopped and then running, which separates the activity gate of R6 from the edge-counted reset release of R8. The three nonzero mode codes are applied in both directions and with both multiplier settings, showing that range and ratio only reach the outputs in serializer configuration. Direction is flipped both ways while a monitor watches every cycle for a swap without an idle cycle, and the reference is stopped for a short and a long window to tell a tolerated pause from a loss.

// File: rtl/serdes_ctl_pkg.sv
// Shared types for the SerDes mode and direction controller.
package serdes_ctl_pkg;

    // Power sequencing states, in bring-up order.
    typedef enum logic [1:0] {
        PS_DOWN = 2'd0,
        PS_WAIT = 2'd1,
        PS_HOLD = 2'd2,
        PS_RUN  = 2'd3
    } pwr_state_t;

    localparam logic [1:0] MODE_OFF = 2'b00;

endpackage

// File: rtl/in_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes each bit is a quasi-static level; no bus coherence is implied.
module in_sync #(
    parameter int         W      = 1,
    parameter int         STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the input through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ref_watchdog.sv
// Reference activity monitor: detects rising edges of the synchronized
// reference and flags a loss when none arrives within TIMEOUT cycles.
// Assumes the reference is slower than clk/2 so no edge is missed.
module ref_watchdog #(
    parameter int TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_lvl,
    output logic ref_edge,
    output logic ref_ok
);
    localparam int CW = $clog2(TIMEOUT);

    logic          ref_prev;
    logic [CW-1:0] idle_cnt;

    // Remember the previous reference level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_prev <= 1'b0;
        else        ref_prev <= ref_lvl;
    end

    assign ref_edge = ref_lvl & ~ref_prev;

    // Count idle cycles; an edge restarts the count and marks the reference good.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            ref_ok   <= 1'b0;
        end else if (ref_edge) begin
            idle_cnt <= '0;
            ref_ok   <= 1'b1;
        end else if (idle_cnt == CW'(TIMEOUT - 1)) begin
            ref_ok   <= 1'b0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R7
    edge_sets_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_edge |=> ref_ok);
endmodule

// File: rtl/pwr_seq.sv
// Power-down / bring-up sequencer. Holds everything off in power-down,
// waits for a live reference before enabling the PLL, then keeps the core
// in reset for HOLD_EDGES reference edges. Assumes pd and ref_ok are
// already synchronous to clk.
module pwr_seq
    import serdes_ctl_pkg::*;
#(
    parameter int HOLD_EDGES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    input  logic ref_ok,
    input  logic ref_edge,
    output logic pll_en,
    output logic core_rst_n,
    output logic run
);
    localparam int HW = (HOLD_EDGES > 1) ? $clog2(HOLD_EDGES) : 1;

    pwr_state_t    state;
    logic [HW-1:0] edge_cnt;

    // Advance the bring-up state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PS_DOWN;
            edge_cnt <= '0;
        end else if (pd) begin
            state    <= PS_DOWN;
            edge_cnt <= '0;
        end else begin
            unique case (state)
                PS_DOWN: state <= PS_WAIT;
                PS_WAIT: begin
                    edge_cnt <= '0;
                    if (ref_ok) state <= PS_HOLD;
                end
                PS_HOLD: begin
                    if (!ref_ok) begin
                        state <= PS_WAIT;
                    end else if (ref_edge) begin
                        if (edge_cnt == HW'(HOLD_EDGES - 1)) state <= PS_RUN;
                        else edge_cnt <= edge_cnt + 1'b1;
                    end
                end
                PS_RUN: if (!ref_ok) state <= PS_WAIT;
                default: state <= PS_DOWN;
            endcase
        end
    end

    assign pll_en     = (state == PS_HOLD) || (state == PS_RUN);
    assign core_rst_n = (state == PS_RUN);
    assign run        = (state == PS_RUN);

    // R1
    pd_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> (!pll_en && !core_rst_n));
    // R6
    pll_needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |-> $past(ref_ok));
    // R8
    release_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> $past(ref_edge));
endmodule

// File: rtl/dir_turn.sv
// Break-before-make direction control. Drops the active driver when the
// requested direction changes and re-enables only after GAP_CYC idle
// cycles. Assumes dir_req is synchronous to clk. GAP_CYC must be >= 1.
module dir_turn #(
    parameter int GAP_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic dir_req,
    output logic drv_ser,
    output logic drv_des
);
    localparam int GW = $clog2(GAP_CYC + 1);

    logic          drv;
    logic          cur_dir;
    logic [GW-1:0] gap_cnt;

    // Manage the driving flag, the latched direction and the idle gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv     <= 1'b0;
            cur_dir <= 1'b0;
            gap_cnt <= '0;
        end else if (!run) begin
            drv     <= 1'b0;
            gap_cnt <= '0;
        end else if (drv) begin
            if (dir_req != cur_dir) begin
                drv     <= 1'b0;
                gap_cnt <= '0;
            end
        end else if (gap_cnt == GW'(GAP_CYC - 1)) begin
            drv     <= 1'b1;
            cur_dir <= dir_req;
        end else begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assign drv_ser = run & drv & cur_dir;
    assign drv_des = run & drv & ~cur_dir;
endmodule

// File: rtl/serdes_mode_ctrl.sv
// Top of the SerDes mode and direction controller. Synchronizes the
// configuration pins, decodes range and multiplier, and ties together the
// reference watchdog, power sequencer and direction turnaround.
// Assumes all inputs other than clk/rst_n are asynchronous levels.
module serdes_mode_ctrl
    import serdes_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REF_TIMEOUT = 256,
    parameter int HOLD_EDGES  = 16,
    parameter int GAP_CYC     = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_a,
    input  logic       sel_b,
    input  logic       dir_in,
    input  logic       mult_sel,
    input  logic       ref_clk,
    output logic       dir_out,
    output logic       ser_en,
    output logic       des_en,
    output logic       mult_frac,
    output logic [1:0] range_code,
    output logic       pll_en,
    output logic       core_rst_n,
    output logic       ref_lost,
    output logic       par_hiz,
    output logic       link_hiz
);
    localparam int NSYNC = 5;

    logic [NSYNC-1:0] raw_in, syn_in;
    logic [1:0]       mode_s;
    logic             dir_s, mult_s, ref_s;
    logic             pd_s, ref_edge, ref_ok, run;

    assign raw_in = {ref_clk, mult_sel, dir_in, sel_b, sel_a};

    in_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
    );

    assign mode_s = syn_in[1:0];
    assign dir_s  = syn_in[2];
    assign mult_s = syn_in[3];
    assign ref_s  = syn_in[4];
    assign pd_s   = (mode_s == MODE_OFF);

    ref_watchdog #(.TIMEOUT(REF_TIMEOUT)) u_wd (
        .clk(clk), .rst_n(rst_n), .ref_lvl(ref_s),
        .ref_edge(ref_edge), .ref_ok(ref_ok)
    );

    pwr_seq #(.HOLD_EDGES(HOLD_EDGES)) u_seq (
        .clk(clk), .rst_n(rst_n), .pd(pd_s), .ref_ok(ref_ok),
        .ref_edge(ref_edge), .pll_en(pll_en), .core_rst_n(core_rst_n),
        .run(run)
    );

    dir_turn #(.GAP_CYC(GAP_CYC)) u_turn (
        .clk(clk), .rst_n(rst_n), .run(run), .dir_req(dir_s),
        .drv_ser(ser_en), .drv_des(des_en)
    );

    // Register the range and ratio decode for the serializer configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_code <= 2'b00;
            mult_frac  <= 1'b0;
        end else if (!pd_s && dir_s) begin
            range_code <= mode_s;
            mult_frac  <= mult_s;
        end else begin
            range_code <= 2'b00;
            mult_frac  <= 1'b0;
        end
    end

    assign dir_out  = ~dir_in;
    assign ref_lost = ~ref_ok;
    assign par_hiz  = ~des_en;
    assign link_hiz = ~ser_en;

    // R9
    ser_then_des_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en |=> !des_en);
    // R9
    des_then_ser_chk: assert property (@(posedge clk) disable iff (!rst_n)
        des_en |=> !ser_en);
    // R1
    pd_drivers_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_s |=> (!ser_en && !des_en));
endmodule

// File: tb/sim_serdes_mode_ctrl.sv
module sim_serdes_mode_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_a = 1'b0, sel_b = 1'b0, dir_in = 1'b0, mult_sel = 1'b0;
    logic ref_clk = 1'b0;
    logic ref_run = 1'b1;
    logic dir_out, ser_en, des_en, mult_frac, pll_en, core_rst_n;
    logic ref_lost, par_hiz, link_hiz;
    logic [1:0] range_code;

    int n_chk = 0;
    int n_bad = 0;
    int swaps = 0;
    int gaps  = 0;
    logic prev_ser = 1'b0, prev_des = 1'b0;
    logic idle_after = 1'b0;

    always #2 clk = ~clk;             // 250 MHz
    always begin                      // reference: 8 clk cycles per period
        #16;
        if (ref_run) ref_clk = ~ref_clk;
    end

    serdes_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b),
        .dir_in(dir_in), .mult_sel(mult_sel), .ref_clk(ref_clk),
        .dir_out(dir_out), .ser_en(ser_en), .des_en(des_en),
        .mult_frac(mult_frac), .range_code(range_code), .pll_en(pll_en),
        .core_rst_n(core_rst_n), .ref_lost(ref_lost), .par_hiz(par_hiz),
        .link_hiz(link_hiz)
    );

    // R9 monitor: swaps without an idle cycle, and idle gaps between directions.
    always @(negedge clk) begin
        if (rst_n) begin
            if ((prev_ser && des_en) || (prev_des && ser_en) || (ser_en && des_en))
                swaps++;
            if ((prev_ser || prev_des) && !ser_en && !des_en) idle_after = 1'b1;
            if (idle_after && (ser_en || des_en)) begin
                if ((ser_en && !prev_ser) || (des_en && !prev_des)) gaps++;
                idle_after = 1'b0;
            end
        end
        prev_ser = ser_en;
        prev_des = des_en;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        {sel_b, sel_a} = m;
    endtask

    task automatic t_reset();
        cyc(20);
        chk("R1", "pll_en",     pll_en, 0);
        chk("R1", "core_rst_n", core_rst_n, 0);
        chk("R1", "ser_en",     ser_en, 0);
        chk("R1", "des_en",     des_en, 0);
        chk("R1", "par_hiz",    par_hiz, 1);
        chk("R1", "link_hiz",   link_hiz, 1);
        chk("R1", "range_code", range_code, 0);
    endtask

    task automatic t_dir_out();
        dir_in = 1'b1; #0.5;
        chk("R3", "dir_out hi-in", dir_out, 0);
        dir_in = 1'b0; #0.5;
        chk("R3", "dir_out lo-in", dir_out, 1);
        dir_in = 1'b1; #0.3;
        chk("R3", "dir_out no clock", dir_out, 0);
        cyc(1);
    endtask

    task automatic t_no_ref();
        ref_run = 1'b0;
        cyc(300);
        dir_in = 1'b1;
        set_mode(2'b01);
        cyc(400);
        chk("R6", "pll_en without ref", pll_en, 0);
        chk("R7", "ref_lost without ref", ref_lost, 1);
        chk("R5", "range in wait", range_code, 1);
    endtask

    task automatic t_bring_up();
        int waited = 0;
        ref_run = 1'b1;
        while (!pll_en && waited < 2000) begin cyc(1); waited++; end
        chk("R6", "pll_en after ref", pll_en, 1);
        chk("R7", "ref_lost cleared", ref_lost, 0);
        cyc(60);
        chk("R8", "core_rst_n held", core_rst_n, 0);
        chk("R2", "ser_en held in reset", ser_en, 0);
        cyc(150);
        chk("R8", "core_rst_n released", core_rst_n, 1);
        chk("R2", "ser_en", ser_en, 1);
        chk("R2", "des_en", des_en, 0);
        chk("R10", "link_hiz", link_hiz, 0);
        chk("R10", "par_hiz", par_hiz, 1);
        chk("R4", "mult_frac ratio 7", mult_frac, 0);
    endtask

    task automatic t_modes();
        mult_sel = 1'b1; cyc(6);
        chk("R4", "mult_frac overclock", mult_frac, 1);
        set_mode(2'b10); cyc(6);
        chk("R5", "range 10", range_code, 2);
        set_mode(2'b11); cyc(6);
        chk("R5", "range 11", range_code, 3);
        chk("R2", "ser_en kept", ser_en, 1);
        set_mode(2'b01); cyc(6);
        chk("R5", "range 01", range_code, 1);
    endtask

    task automatic t_turn();
        dir_in = 1'b0; cyc(10);
        chk("R2", "des_en", des_en, 1);
        chk("R2", "ser_en off", ser_en, 0);
        chk("R10", "par_hiz", par_hiz, 0);
        chk("R10", "link_hiz", link_hiz, 1);
        chk("R4", "mult_frac in deser", mult_frac, 0);
        chk("R5", "range in deser", range_code, 0);
        dir_in = 1'b1; cyc(10);
        chk("R2", "ser_en back", ser_en, 1);
        chk("R9", "swap without gap", swaps, 0);
        chk("R9", "gaps seen", gaps, 2);
    endtask

    task automatic t_ref_loss();
        dir_in = 1'b0; cyc(10);
        ref_run = 1'b0;
        cyc(120);
        chk("R7", "short pause tolerated", ref_lost, 0);
        chk("R7", "des_en during pause", des_en, 1);
        cyc(250);
        chk("R7", "ref_lost", ref_lost, 1);
        chk("R7", "pll_en dropped", pll_en, 0);
        chk("R7", "core_rst_n dropped", core_rst_n, 0);
        chk("R7", "des_en dropped", des_en, 0);
        ref_run = 1'b1;
        cyc(250);
        chk("R8", "recovered release", core_rst_n, 1);
        chk("R2", "des_en recovered", des_en, 1);
    endtask

    task automatic t_pd();
        set_mode(2'b00); cyc(8);
        chk("R1", "pll_en", pll_en, 0);
        chk("R1", "core_rst_n", core_rst_n, 0);
        chk("R1", "des_en", des_en, 0);
        chk("R1", "par_hiz", par_hiz, 1);
        chk("R1", "link_hiz", link_hiz, 1);
        dir_in = 1'b1; cyc(8);
        chk("R1", "range in pd", range_code, 0);
        chk("R4", "mult_frac in pd", mult_frac, 0);
        chk("R1", "ser_en in pd", ser_en, 0);
    endtask

    initial begin : watchdog
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        cyc(5);
        rst_n = 1'b1;
        t_reset();
        t_dir_out();
        t_no_ref();
        t_bring_up();
        t_modes();
        t_turn();
        t_ref_loss();
        t_pd();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule